// File: doc/BRIEF.md
# Peripheral Clock Prescaler with Fixed and Programmable Taps

The block turns a base clock strobe into a set of count-source strobes for timers and serial ports. One select input picks the base: the main clock strobe or the on-chip oscillator strobe. From every base strobe that passes the gate, the block forms four taps. Three are fixed: every strobe, every 8th strobe and every 32nd strobe. The fourth divides by 2n, where n comes from a 4-bit field, and n = 0 passes every strobe through. A separate A/D strobe follows the main clock strobe whatever the select input says.

A gate stops the four taps in two cases: in low-power mode, and in wait mode when the wait-stop enable is set. The A/D strobe stops only in low-power mode and keeps running through wait mode. While the gate is closed the tap counters hold their values, so the sequence resumes where it stopped. Gating acts on whole base strobes, so no shortened period is ever produced. Each output is a registered single-cycle pulse that appears one clock after the input strobe that caused it.

Top module: `pcp_top`

## Requirements
- R1: After reset is asserted, all five outputs are 0.
- R2: base_sel_i = 0 selects main_stb_i as the base and base_sel_i = 1 selects osc_stb_i. Each base strobe that is not gated produces one pulse on tap1_o in the following clock cycle. A strobe on the unselected input has no effect on any tap.
- R3: tap8_o pulses on the 8th, 16th, and each further multiple of 8 passed base strobes counted from reset. tap32_o pulses on each multiple of 32 passed strobes. Each such pulse coincides with a tap1_o pulse.
- R4: For div_n_i = n in 1..15, tap2n_o pulses on the first passed strobe after reset and then once every 2n passed strobes.
- R5: For div_n_i = 0, tap2n_o pulses on every passed strobe.
- R6: A change of div_n_i takes effect at the next tap2n_o pulse. The period in progress completes with the old value, and the new period starts at that pulse.
- R7: With wait_i = 1 and wait_stop_i = 1, no pulse appears on tap1_o, tap8_o, tap32_o or tap2n_o. With wait_stop_i = 0, wait_i has no effect.
- R8: With lowpwr_i = 1, all five outputs stay 0.
- R9: adc_o pulses one cycle after each main_stb_i when lowpwr_i = 0, regardless of base_sel_i, wait_i and wait_stop_i. A strobe on osc_stb_i never drives adc_o.
- R10: Base strobes that are gated do not advance the tap counters. When the gate opens again, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| main_stb_i | input | 1 | Main clock strobe |
| osc_stb_i | input | 1 | On-chip oscillator strobe |
| base_sel_i | input | 1 | Base select: 0 main, 1 oscillator |
| div_n_i | input | 4 | n for the 2n tap; 0 means bypass |
| wait_stop_i | input | 1 | Stop the taps while in wait mode |
| wait_i | input | 1 | Device is in wait mode |
| lowpwr_i | input | 1 | Device is in low-power mode |
| tap1_o | output | 1 | Divide-by-1 strobe |
| tap8_o | output | 1 | Divide-by-8 strobe |
| tap32_o | output | 1 | Divide-by-32 strobe |
| tap2n_o | output | 1 | Divide-by-2n strobe |
| adc_o | output | 1 | A/D clock strobe |

## Verification
The hardest case to reach from the ports is a held counter: it must stay put across a stretch of gated strobes and then resume in phase. The stimulus passes a known number of strobes and then raises low-power mode for a run of strobes that is not a multiple of 8. After lowering it, the bench expects the next tap8_o pulse on exactly the strobe that completes the count of eight. A change of n in the middle of a period is reached the same way. The bench counts strobes after a known reload and expects the old period to complete before the new one starts.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int unsigned N_W      = 4;
  localparam int unsigned CNT2N_W  = N_W + 1;
  localparam int unsigned FIX_CNT_W = 5;
  localparam int unsigned NUM_FIX  = 2;

  typedef struct packed {
    logic t1;
    logic t8;
    logic t32;
    logic t2n;
    logic adc;
  } pcp_taps_t;
endpackage

// File: rtl/pcp_gate.sv
module pcp_gate (
  input  logic main_stb_i,
  input  logic osc_stb_i,
  input  logic base_sel_i,
  input  logic wait_stop_i,
  input  logic wait_i,
  input  logic lowpwr_i,
  output logic base_go_o,
  output logic adc_go_o
);
  logic base_stb;
  logic tap_hold;

  assign base_stb  = base_sel_i ? osc_stb_i : main_stb_i;
  // whole strobes are either passed or dropped
  assign tap_hold  = lowpwr_i | (wait_i & wait_stop_i);
  assign base_go_o = base_stb & ~tap_hold;
  assign adc_go_o  = main_stb_i & ~lowpwr_i;
endmodule

// File: rtl/pcp_fixed_taps.sv
module pcp_fixed_taps #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned NUM_TAP = 2,
  parameter int unsigned TAP_LOG [NUM_TAP] = '{3, 5}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  output logic [NUM_TAP-1:0] hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (go_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAP; g++) begin : g_tap
    localparam int unsigned LW = TAP_LOG[g];
    assign hit_o[g] = go_i & (&cnt_q[LW-1:0]);
  end
endmodule

// File: rtl/pcp_prog_tap.sv
module pcp_prog_tap #(
  parameter int unsigned N_W = 4,
  localparam int unsigned C_W = N_W + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [N_W-1:0] div_n_i,
  output logic           hit_o
);
  logic [C_W-1:0] cnt_q;
  logic [C_W-1:0] reload;

  // 2n-1, or 0 for bypass
  assign reload = (div_n_i == '0) ? '0 : ({div_n_i, 1'b0} - 1'b1);
  assign hit_o  = go_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (hit_o) cnt_q <= reload;
    else if (go_i)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pcp_top.sv
module pcp_top
  import pcp_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           main_stb_i,
  input  logic           osc_stb_i,
  input  logic           base_sel_i,
  input  logic [N_W-1:0] div_n_i,
  input  logic           wait_stop_i,
  input  logic           wait_i,
  input  logic           lowpwr_i,
  output logic           tap1_o,
  output logic           tap8_o,
  output logic           tap32_o,
  output logic           tap2n_o,
  output logic           adc_o
);
  logic               base_go;
  logic               adc_go;
  logic [NUM_FIX-1:0] fix_hit;
  logic               prog_hit;
  pcp_taps_t          taps_d, taps_q;

  pcp_gate u_gate (
    .main_stb_i (main_stb_i),
    .osc_stb_i  (osc_stb_i),
    .base_sel_i (base_sel_i),
    .wait_stop_i(wait_stop_i),
    .wait_i     (wait_i),
    .lowpwr_i   (lowpwr_i),
    .base_go_o  (base_go),
    .adc_go_o   (adc_go)
  );

  pcp_fixed_taps #(
    .CNT_W  (FIX_CNT_W),
    .NUM_TAP(NUM_FIX),
    .TAP_LOG('{3, 5})
  ) u_fixed (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (base_go),
    .hit_o (fix_hit)
  );

  pcp_prog_tap #(.N_W(N_W)) u_prog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (base_go),
    .div_n_i(div_n_i),
    .hit_o  (prog_hit)
  );

  always_comb begin
    taps_d.t1  = base_go;
    taps_d.t8  = fix_hit[0];
    taps_d.t32 = fix_hit[1];
    taps_d.t2n = prog_hit;
    taps_d.adc = adc_go;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taps_q <= '0;
    else         taps_q <= taps_d;
  end

  assign tap1_o  = taps_q.t1;
  assign tap8_o  = taps_q.t8;
  assign tap32_o = taps_q.t32;
  assign tap2n_o = taps_q.t2n;
  assign adc_o   = taps_q.adc;
endmodule

// File: rtl/pcp_top_chk.sv
module pcp_top_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       main_stb_i,
  input logic       osc_stb_i,
  input logic       base_sel_i,
  input logic [3:0] div_n_i,
  input logic       wait_stop_i,
  input logic       wait_i,
  input logic       lowpwr_i,
  input logic       tap1_o,
  input logic       tap8_o,
  input logic       tap32_o,
  input logic       tap2n_o,
  input logic       adc_o
);
  logic sel_stb;
  logic pass;
  assign sel_stb = base_sel_i ? osc_stb_i : main_stb_i;
  assign pass    = sel_stb && !lowpwr_i && !(wait_i && wait_stop_i);

  AST_UNSEL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_stb |=> !tap1_o && !tap8_o && !tap32_o && !tap2n_o); // R2
  AST_TAP1_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass |=> tap1_o); // R2
  AST_TAP8_ON_TAP1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap8_o |-> tap1_o); // R3
  AST_TAP32_ON_TAP8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap32_o |-> tap8_o); // R3
  AST_BYPASS_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass && div_n_i == 4'd0) |=> tap2n_o); // R5
  AST_WAIT_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && wait_stop_i) |=> !tap1_o && !tap8_o && !tap32_o && !tap2n_o); // R7
  AST_LOWPWR_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_i |=> !tap1_o && !tap2n_o && !adc_o); // R8
  AST_ADC_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_stb_i && !lowpwr_i) |=> adc_o); // R9
  AST_ADC_MAIN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_stb_i |=> !adc_o); // R9
endmodule

bind pcp_top pcp_top_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .main_stb_i (main_stb_i),
  .osc_stb_i  (osc_stb_i),
  .base_sel_i (base_sel_i),
  .div_n_i    (div_n_i),
  .wait_stop_i(wait_stop_i),
  .wait_i     (wait_i),
  .lowpwr_i   (lowpwr_i),
  .tap1_o     (tap1_o),
  .tap8_o     (tap8_o),
  .tap32_o    (tap32_o),
  .tap2n_o    (tap2n_o),
  .adc_o      (adc_o)
);

// File: tb/pcp_top_tb.sv
module pcp_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_stb = 1'b0, osc_stb = 1'b0, sel = 1'b0;
  logic [3:0] n = 4'd0;
  logic       ws = 1'b0, wt = 1'b0, lp = 1'b0;
  logic       t1, t8, t32, t2n, adc;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  pcp_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .main_stb_i(main_stb), .osc_stb_i(osc_stb),
    .base_sel_i(sel), .div_n_i(n), .wait_stop_i(ws), .wait_i(wt), .lowpwr_i(lp),
    .tap1_o(t1), .tap8_o(t8), .tap32_o(t32), .tap2n_o(t2n), .adc_o(adc)
  );

  // sel, n, ws, wait, lp, exp tap1, tap8, tap32, tap2n, adc over 64 cycles
  typedef struct packed {
    logic       sel; logic [3:0] n; logic ws; logic wt; logic lp;
    logic [7:0] e1; logic [7:0] e8; logic [7:0] e32; logic [7:0] e2n; logic [7:0] ea;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 8'd64, 8'd8, 8'd2, 8'd64, 8'd64},
    '{1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 8'd32, 8'd4, 8'd1, 8'd32, 8'd64},
    '{1'b0, 4'd3,  1'b0, 1'b0, 1'b0, 8'd64, 8'd8, 8'd2, 8'd11, 8'd64},
    '{1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 8'd32, 8'd4, 8'd1, 8'd2,  8'd64},
    '{1'b0, 4'd1,  1'b1, 1'b1, 1'b0, 8'd0,  8'd0, 8'd0, 8'd0,  8'd64},
    '{1'b0, 4'd1,  1'b0, 1'b1, 1'b0, 8'd64, 8'd8, 8'd2, 8'd32, 8'd64},
    '{1'b0, 4'd1,  1'b0, 1'b0, 1'b1, 8'd0,  8'd0, 8'd0, 8'd0,  8'd0},
    '{1'b1, 4'd2,  1'b1, 1'b0, 1'b0, 8'd32, 8'd4, 8'd1, 8'd8,  8'd64}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    main_stb = 1'b0; osc_stb = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one cycle of strobes, sample after the edge that registers them
  task automatic step(input logic m, input logic o);
    @(negedge clk);
    main_stb = m; osc_stb = o;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c1, c8, c32, c2n, ca;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset outputs", int'({t1, t8, t32, t2n, adc}), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_reset();
      sel = VECS[v].sel; n = VECS[v].n; ws = VECS[v].ws; wt = VECS[v].wt; lp = VECS[v].lp;
      c1 = 0; c8 = 0; c32 = 0; c2n = 0; ca = 0;
      for (int i = 0; i < 64; i++) begin
        step(1'b1, (i % 2) == 0);
        c1 += int'(t1); c8 += int'(t8); c32 += int'(t32); c2n += int'(t2n); ca += int'(adc);
      end
      chk($sformatf("R2/R7/R8 tap1 vec%0d", v), c1, int'(VECS[v].e1));
      chk($sformatf("R3 tap8 vec%0d", v), c8, int'(VECS[v].e8));
      chk($sformatf("R3 tap32 vec%0d", v), c32, int'(VECS[v].e32));
      chk($sformatf("R4/R5 tap2n vec%0d", v), c2n, int'(VECS[v].e2n));
      chk($sformatf("R9 adc vec%0d", v), ca, int'(VECS[v].ea));
    end
    sel = 1'b0; ws = 1'b0; wt = 1'b0; lp = 1'b0;

    // R6: n change mid-period
    n = 4'd1;
    do_reset();
    step(1'b1, 1'b0);
    chk("R6 first pulse", int'(t2n), 1);
    n = 4'd3;
    step(1'b1, 1'b0);
    chk("R6 old period runs", int'(t2n), 0);
    step(1'b1, 1'b0);
    chk("R6 old period ends", int'(t2n), 1);
    c2n = 0;
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0);
      c2n += int'(t2n);
    end
    chk("R6 new period quiet", c2n, 0);
    step(1'b1, 1'b0);
    chk("R6 new period pulse", int'(t2n), 1);

    // R10: hold while gated, resume in phase
    n = 4'd0;
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    lp = 1'b1;
    c1 = 0;
    for (int i = 0; i < 11; i++) begin
      step(1'b1, 1'b0);
      c1 += int'(t1) + int'(t8) + int'(adc);
    end
    chk("R8 lowpwr silent", c1, 0);
    lp = 1'b0;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R10 no early tap8", int'(t8), 0);
    step(1'b1, 1'b0);
    chk("R10 tap8 on held count", int'(t8), 1);

    // R2/R9: unselected strobe ignored, adc tied to main only
    do_reset();
    sel = 1'b0;
    step(1'b0, 1'b1);
    chk("R2 osc ignored when main selected", int'(t1), 0);
    chk("R9 osc never drives adc", int'(adc), 0);
    sel = 1'b1;
    step(1'b0, 1'b1);
    chk("R2 osc selected drives tap1", int'(t1), 1);
    chk("R9 adc quiet without main", int'(adc), 0);
    step(1'b1, 1'b0);
    chk("R2 main ignored when osc selected", int'(t1), 0);
    chk("R9 adc with osc selected", int'(adc), 1);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    main_stb = 1'b1; osc_stb = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", int'({t1, t8, t32, t2n, adc}), 0);
    @(negedge clk);
    main_stb = 1'b0; osc_stb = 1'b0;
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule